// File: doc/BRIEF.md
# Saturating Quarter Tally with Two-Digit Display

This block counts presses of one coin button. Every accepted press adds a quarter to a running total. The total is shown in cents on two active-low seven-segment digits. The button arrives asynchronously to the clock, so it first passes through a chain of flip-flops. A rising-edge detector then turns each press into a single one-cycle step, however long the button is held. The tally stops at four quarters, and from then on further presses have no effect. A synchronous active-high reset returns it to zero.

The tally is a five-state machine, and its state encoding is the 3-bit count itself:

- `TALLY_NONE` (0), `TALLY_ONE` (1), `TALLY_TWO` (2), `TALLY_THREE` (3), `TALLY_FULL` (4).
- Transition ADVANCE: on a step pulse, each state moves to the next one.
- Transition HOLD: with no pulse, the state stays where it is.
- Transition SATURATE: `TALLY_FULL` loops to itself whether or not a pulse is present.
- Transition CLEAR: reset sends every state to `TALLY_NONE`.

The display shows 00, 25, 50, 75, and then "10" for one dollar.

Top module: `coin_press_counter`

## Requirements
- R1: The button passes through two flip-flops before the edge detector. If `coin_btn` goes high before clock edge k, `quarters` shows the increment after edge k+2 and not earlier.
- R2: A press held high for any number of cycles adds exactly one to the tally. While no new rising edge reaches the edge detector, `quarters` stays unchanged.
- R3: Each accepted press increments `quarters` by exactly one. This holds for back-to-back presses that are separated by a single low cycle.
- R4: The tally saturates at 4. Presses made while `quarters` is 4 leave it at 4, and the display stays unchanged.
- R5: The segment code is 7 bits wide, active low, ordered g down to a (bit 6 = g, bit 0 = a). The digit codes are: 0 = 1000000, 1 = 1111001, 2 = 0100100, 5 = 0010010, 7 = 1111000. For `quarters` values 0, 1, 2, 3 and 4, the tens/ones digits shown are 0/0, 2/5, 5/0, 7/5 and 1/0.
- R6: A synchronous active-high reset clears the tally, the synchronizer stages and the edge-detector history. After the first clock edge with `rst` high, `quarters` reads 0. A button still held high when reset is released is counted once, as a fresh press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_btn | input | 1 | Raw coin button, asynchronous, assumed free of bounce |
| quarters | output | 3 | Number of quarters counted, 0 to 4 |
| seg_tens | output | 7 | Active-low segment code of the left digit |
| seg_ones | output | 7 | Active-low segment code of the right digit |

## Verification
The assertions assume that the button is clean: each press is one low-to-high transition, and the low gap before the next press lasts at least one clock cycle. They also assume that reset is held long enough for the synchronizer stages to clear. The stimulus drives the button only on falling clock edges and never sends a glitch shorter than one cycle. Every low gap is at least one full cycle long, and reset is held for several cycles. Within these limits, the bench sweeps hold lengths, gap lengths and press counts past saturation.

// File: rtl/coin_pkg.sv
package coin_pkg;

    localparam int TALLY_W = 3;
    localparam int SEG_W   = 7;
    localparam int DIGIT_W = 4;

    typedef enum logic [TALLY_W-1:0] {
        TALLY_NONE  = 3'd0,
        TALLY_ONE   = 3'd1,
        TALLY_TWO   = 3'd2,
        TALLY_THREE = 3'd3,
        TALLY_FULL  = 3'd4
    } tally_e;

    typedef logic [SEG_W-1:0]   seg_t;
    typedef logic [DIGIT_W-1:0] digit_t;

    // Active-low segment code, bit 6 = g ... bit 0 = a.
    function automatic seg_t digit_to_seg(input digit_t d);
        seg_t s;
        unique case (d)
            4'd0:    s = 7'b1000000;
            4'd1:    s = 7'b1111001;
            4'd2:    s = 7'b0100100;
            4'd3:    s = 7'b0110000;
            4'd4:    s = 7'b0011001;
            4'd5:    s = 7'b0010010;
            4'd6:    s = 7'b0000010;
            4'd7:    s = 7'b1111000;
            4'd8:    s = 7'b0000000;
            4'd9:    s = 7'b0010000;
            default: s = 7'b0111111;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/coin_sync.sv
module coin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/coin_edge.sv
module coin_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    logic level_prev;

    always_ff @(posedge clk) begin
        if (rst) level_prev <= 1'b0;
        else     level_prev <= level;
    end

    assign pulse = level & ~level_prev;

    // A held level yields a single step.
    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

// File: rtl/coin_tally_fsm.sv
module coin_tally_fsm
    import coin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    output logic [TALLY_W-1:0] tally
);
    tally_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= TALLY_NONE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            TALLY_NONE:  state_d = step ? TALLY_ONE   : TALLY_NONE;
            TALLY_ONE:   state_d = step ? TALLY_TWO   : TALLY_ONE;
            TALLY_TWO:   state_d = step ? TALLY_THREE : TALLY_TWO;
            TALLY_THREE: state_d = step ? TALLY_FULL  : TALLY_THREE;
            TALLY_FULL:  state_d = TALLY_FULL;
            default:     state_d = TALLY_NONE;
        endcase
    end

    assign tally = state_q;

    assert_advance_one_R3: assert property (@(posedge clk) disable iff (rst)
        (step && tally != 3'd4) |=> (tally == $past(tally) + 3'd1));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(tally));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (tally == 3'd4) |=> (tally == 3'd4));

    assert_reset_clear_R6: assert property (@(posedge clk)
        rst |=> (tally == 3'd0));
endmodule

// File: rtl/coin_seg_decode.sv
module coin_seg_decode
    import coin_pkg::*;
(
    input  logic [TALLY_W-1:0] tally,
    output logic [SEG_W-1:0]   seg_tens,
    output logic [SEG_W-1:0]   seg_ones
);
    digit_t tens_d, ones_d;

    always_comb begin
        unique case (tally)
            3'd1:    begin tens_d = 4'd2; ones_d = 4'd5; end
            3'd2:    begin tens_d = 4'd5; ones_d = 4'd0; end
            3'd3:    begin tens_d = 4'd7; ones_d = 4'd5; end
            3'd4:    begin tens_d = 4'd1; ones_d = 4'd0; end
            default: begin tens_d = 4'd0; ones_d = 4'd0; end
        endcase
    end

    assign seg_tens = digit_to_seg(tens_d);
    assign seg_ones = digit_to_seg(ones_d);
endmodule

// File: rtl/coin_press_counter.sv
module coin_press_counter
    import coin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       coin_btn,
    output logic [2:0] quarters,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_ones
);
    logic btn_sync;
    logic btn_step;

    coin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (coin_btn),
        .sync_out (btn_sync)
    );

    coin_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (btn_sync),
        .pulse (btn_step)
    );

    coin_tally_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .step  (btn_step),
        .tally (quarters)
    );

    coin_seg_decode u_dec (
        .tally    (quarters),
        .seg_tens (seg_tens),
        .seg_ones (seg_ones)
    );

    // A step is only possible once the raw input has crossed both stages.
    assert_sync_delay_R1: assert property (@(posedge clk) disable iff (rst)
        btn_step |-> $past(coin_btn, 2));

    // The empty tally shows 00 on the display.
    assert_zero_display_R5: assert property (@(posedge clk) disable iff (rst)
        (quarters == 3'd0) |-> (seg_tens == 7'b1000000 && seg_ones == 7'b1000000));
endmodule

// File: tb/sim_coin_press_counter.sv
`timescale 1ns/1ps
module sim_coin_press_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coin_btn = 1'b0;
    logic [2:0] quarters;
    logic [6:0] seg_tens, seg_ones;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    coin_press_counter u0 (
        .clk(clk), .rst(rst), .coin_btn(coin_btn),
        .quarters(quarters), .seg_tens(seg_tens), .seg_ones(seg_ones)
    );

    function automatic logic [6:0] exp_seg(input int d);
        case (d)
            0: return 7'b1000000;
            1: return 7'b1111001;
            2: return 7'b0100100;
            5: return 7'b0010010;
            7: return 7'b1111000;
            default: return 7'b1111111;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int n);
        int cents, tens, ones;
        logic [6:0] et, eo;
        cents = 25 * n;
        if (n == 4) begin tens = 1; ones = 0; end
        else begin tens = cents / 10; ones = cents % 10; end
        et = exp_seg(tens);
        eo = exp_seg(ones);
        total++;
        if (quarters !== 3'(n) || seg_tens !== et || seg_ones !== eo) begin
            bad++;
            $display("FAIL %s: quarters=%0d tens=%b ones=%b expected quarters=%0d tens=%b ones=%b",
                     tag, quarters, seg_tens, seg_ones, n, et, eo);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        coin_btn = 1'b0;
        repeat (4) tick();
        rst = 1'b0;
    endtask

    task automatic press(input int hold, input int gap);
        coin_btn = 1'b1;
        repeat (hold) tick();
        coin_btn = 1'b0;
        repeat (gap) tick();
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Reset state
        repeat (3) tick();
        check("R6 reset state", 0);
        rst = 1'b0;
        tick();
        check("R6 idle after reset", 0);

        // R1: latency through the two synchronizer stages
        coin_btn = 1'b1;
        tick(); check("R1 after edge 1", 0);
        tick(); check("R1 after edge 2", 0);
        tick(); check("R1 after edge 3", 1);
        // R2: long hold adds nothing more
        repeat (40) tick();
        check("R2 long hold", 1);
        coin_btn = 1'b0;
        repeat (4) tick();
        check("R2 after release", 1);

        // R3/R4/R5: sweep hold, gap and press count
        for (int hold = 1; hold <= 6; hold++) begin
            for (int gap = 1; gap <= 3; gap++) begin
                for (int n = 0; n <= 6; n++) begin
                    do_reset();
                    for (int k = 0; k < n; k++) press(hold, gap);
                    repeat (4) tick();
                    check((n > 4) ? "R4 saturation sweep" : "R3 R5 count sweep",
                          (n > 4) ? 4 : n);
                end
            end
        end

        // R3: back-to-back single-cycle presses, checked after each one
        do_reset();
        for (int k = 1; k <= 3; k++) begin
            press(1, 1);
            repeat (2) tick();
            check("R3 back-to-back", k);
        end

        // R4: presses at full leave the tally and display alone
        press(1, 1);
        repeat (3) tick();
        check("R4 reach full", 4);
        for (int k = 0; k < 5; k++) begin
            press(2, 1);
            repeat (3) tick();
            check("R4 press while full", 4);
        end

        // R6: reset with button held, then the held press counts once
        do_reset();
        press(1, 2); press(1, 2); press(1, 2);
        repeat (3) tick();
        check("R6 before reset", 3);
        coin_btn = 1'b1;
        rst = 1'b1;
        tick();
        check("R6 reset while held", 0);
        repeat (3) tick();
        rst = 1'b0;
        repeat (4) tick();
        check("R6 held press counted once", 1);
        repeat (10) tick();
        check("R6 held press no repeat", 1);
        coin_btn = 1'b0;
        repeat (3) tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule